// File: doc/BRIEF.md
# Serial Register Slave with Per-Function Read Latency

This block is a four-wire serial slave (clock, active-low select, host-to-slave data, slave-to-host data) that gives a host access to a small byte-addressed register space. Every transaction opens with a 32-bit command word. The word chooses read or write, one of four function numbers, and a starting byte address. After the command, data bytes follow for as long as the select line stays low. The address advances by one for each data byte.

The register space holds four kinds of register. A fixed 32-bit signature lets the host confirm that the link works. A 32-bit scratch area can be written and read back. A 16-bit status word reports the function-2 enable and ready flags, which come from local logic, together with a constant maximum packet size. Four one-byte latency registers set, per function, how many zero filler bytes the slave shifts out on a read before the first real data byte. This gives a slow back end time to prepare its data.

The serial inputs are synchronised into the system clock domain and sampled there. The host clock must therefore run several times slower than the system clock.

Top module: `spi_reg_slave`

## Requirements
- R1: The command is 32 bits, most significant bit first. Bit 31 is 1 for a write and 0 for a read. Bits 30:29 give the function number. Bits 28:12 give the start byte address. Bit 11 is unused. Bits 10:0 carry a length that does not limit the transfer. Data bytes continue while select is low, and the address rises by one per byte. The slave samples on the rising serial clock edge and drives on the falling edge (mode 0).
- R2: Bytes 0x14, 0x15, 0x16 and 0x17 read back as 0xAD, 0xBE, 0xED and 0xFE. This is the word 0xFEEDBEAD with its least significant byte at the lowest address.
- R3: Bytes 0x18 to 0x1B reset to zero and read back the last value the host wrote to each of them.
- R4: Bytes 0x1C, 0x1D, 0x1E and 0x1F are the latency registers for functions 0, 1, 2 and 3. They reset to 0, 4, 0 and 0, and the host can write them.
- R5: A read issued with function f shifts out as many 0x00 bytes as latency register f holds, then the register data starting at the command address. Writes insert no filler bytes.
- R6: Byte 0x0E reads as {6'b0, f2_ready, f2_enabled}, so bit 0 is the enable flag and bit 1 is the ready flag. Byte 0x0F reads as 0x20. Bits 15:2 of the word at 0x0E therefore hold 0x800.
- R7: Writes to 0x0E-0x0F, to 0x14-0x17 and to unmapped addresses change nothing. Every address bit is decoded, and a read of an unmapped address returns 0x00.
- R8: MISO is 0 throughout the command word and throughout write transactions. It returns to 0 within 4 system clocks after select rises and stays at 0 while select is high.
- R9: Raising select in the middle of a command discards the partial bits. The next transaction decodes a fresh 32-bit command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Host serial clock |
| spi_cs_n | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Host-to-slave serial data |
| spi_miso | output | 1 | Slave-to-host serial data, registered |
| f2_enabled | input | 1 | Function-2 enabled flag from local logic |
| f2_ready | input | 1 | Function-2 ready flag from local logic |

## Verification
The hardest situation to reach from the ports is a command cut off halfway. The partial bits must leave no trace in the bit counter, and the next select-low period must decode from scratch. The stimulus raises select after twelve command bits and then immediately reads the signature, so any leftover count would misalign every returned byte. The latency path is driven by rewriting the latency registers through the serial port itself. Reads are then issued under different function numbers, and the scoreboard checks both the number of zero fillers and the data that follows them.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int ADDR_W = 17;
  localparam int CMD_W  = 32;
  localparam int BYTE_W = 8;
  localparam int NFUNC  = 4;
  localparam int LEN_W  = 11;

  localparam logic [ADDR_W-1:0] A_INFO = ADDR_W'(17'h0E);
  localparam logic [ADDR_W-1:0] A_SIG  = ADDR_W'(17'h14);
  localparam logic [ADDR_W-1:0] A_SCR  = ADDR_W'(17'h18);
  localparam logic [ADDR_W-1:0] A_LAT  = ADDR_W'(17'h1C);

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    logic              wr;
    logic [1:0]        fn;
    logic [ADDR_W-1:0] addr;
    logic              spare;
    logic [LEN_W-1:0]  len;
  } cmd_t;
endpackage

// File: rtl/spi_link.sv
module spi_link #(
  parameter int SYNC   = 2,
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              active,
  output logic              cmd_valid,
  output logic              byte_valid,
  output logic              tx_load,
  output logic [WORD_W-1:0] rx_word,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              miso
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [SYNC-1:0]   sclk_sh, cs_sh, mosi_sh;
  logic              sclk_s, sclk_p, cs_s, mosi_s, rise, fall;
  logic              in_data, pend;
  logic [CNT_W-1:0]  bitcnt;
  logic [WORD_W-2:0] sreg;
  logic [BYTE_W-1:0] txsr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sh <= '0;
      cs_sh   <= '1;
      mosi_sh <= '0;
    end else begin
      sclk_sh <= {sclk_sh[SYNC-2:0], sclk};
      cs_sh   <= {cs_sh[SYNC-2:0], cs_n};
      mosi_sh <= {mosi_sh[SYNC-2:0], mosi};
    end
  end

  assign sclk_s     = sclk_sh[SYNC-1];
  assign cs_s       = cs_sh[SYNC-1];
  assign mosi_s     = mosi_sh[SYNC-1];
  assign active     = ~cs_s;
  assign rise       = sclk_s & ~sclk_p & ~cs_s;
  assign fall       = ~sclk_s & sclk_p & ~cs_s;
  assign rx_word    = {sreg, mosi_s};
  assign cmd_valid  = rise & ~in_data & (bitcnt == CNT_W'(WORD_W - 1));
  assign byte_valid = rise & in_data & (bitcnt == CNT_W'(BYTE_W - 1));
  assign tx_load    = fall & pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p  <= 1'b0;
      sreg    <= '0;
      bitcnt  <= '0;
      in_data <= 1'b0;
      pend    <= 1'b0;
      txsr    <= '0;
      miso    <= 1'b0;
    end else begin
      sclk_p <= sclk_s;
      if (cs_s) begin
        bitcnt  <= '0;
        in_data <= 1'b0;
        pend    <= 1'b0;
        txsr    <= '0;
        miso    <= 1'b0;
      end else begin
        if (rise) begin
          sreg <= rx_word[WORD_W-2:0];
          if (cmd_valid || byte_valid) begin
            bitcnt  <= '0;
            in_data <= 1'b1;
            pend    <= 1'b1;
          end else begin
            bitcnt <= bitcnt + 1'b1;
          end
        end
        if (fall) begin
          if (pend) begin
            miso <= tx_byte[BYTE_W-1];
            txsr <= {tx_byte[BYTE_W-2:0], 1'b0};
            pend <= 1'b0;
          end else begin
            miso <= txsr[BYTE_W-1];
            txsr <= {txsr[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import spi_reg_pkg::*;
#(
  parameter logic [31:0] SIGNATURE  = 32'hFEEDBEAD,
  parameter logic [13:0] MAX_PKT    = 14'h800,
  parameter logic [7:0]  F1_LAT_RST = 8'd4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  byte_t                   wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output byte_t                   rd_data,
  input  logic                    f2_en,
  input  logic                    f2_rdy,
  output logic [NFUNC*BYTE_W-1:0] lat_bytes
);
  localparam int SCR_N = 4;
  localparam int SIG_N = 4;

  byte_t scr [SCR_N];
  byte_t lat [NFUNC];

  for (genvar i = 0; i < SCR_N; i++) begin : g_scr
    always_ff @(posedge clk) begin
      if (rst) scr[i] <= '0;
      else if (wr_en && wr_addr == A_SCR + ADDR_W'(i)) scr[i] <= wr_data;
    end
  end

  for (genvar f = 0; f < NFUNC; f++) begin : g_lat
    localparam byte_t RST_V = (f == 1) ? F1_LAT_RST : '0;
    always_ff @(posedge clk) begin
      if (rst) lat[f] <= RST_V;
      else if (wr_en && wr_addr == A_LAT + ADDR_W'(f)) lat[f] <= wr_data;
    end
    assign lat_bytes[f*BYTE_W +: BYTE_W] = lat[f];
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_INFO) rd_data = {MAX_PKT[5:0], f2_rdy, f2_en};
    if (rd_addr == A_INFO + ADDR_W'(1)) rd_data = MAX_PKT[13:6];
    for (int i = 0; i < SIG_N; i++)
      if (rd_addr == A_SIG + ADDR_W'(i)) rd_data = SIGNATURE[i*BYTE_W +: BYTE_W];
    for (int i = 0; i < SCR_N; i++)
      if (rd_addr == A_SCR + ADDR_W'(i)) rd_data = scr[i];
    for (int f = 0; f < NFUNC; f++)
      if (rd_addr == A_LAT + ADDR_W'(f)) rd_data = lat[f];
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int          SYNC       = 2,
  parameter logic [31:0] SIGNATURE  = 32'hFEEDBEAD,
  parameter logic [13:0] MAX_PKT    = 14'h800,
  parameter logic [7:0]  F1_LAT_RST = 8'd4
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  input  logic f2_enabled,
  input  logic f2_ready
);
  logic                    active, cmd_valid, byte_valid, tx_load;
  logic [CMD_W-1:0]        rx_word;
  cmd_t                    cmd;
  byte_t                   tx_byte, rd_data, dly_q;
  logic                    wr_q;
  logic [ADDR_W-1:0]       addr_q;
  logic [NFUNC*BYTE_W-1:0] lat_bytes;

  spi_link #(.SYNC(SYNC), .WORD_W(CMD_W), .BYTE_W(BYTE_W)) u_link (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .active(active), .cmd_valid(cmd_valid), .byte_valid(byte_valid),
    .tx_load(tx_load), .rx_word(rx_word), .tx_byte(tx_byte), .miso(spi_miso)
  );

  reg_bank #(.SIGNATURE(SIGNATURE), .MAX_PKT(MAX_PKT), .F1_LAT_RST(F1_LAT_RST)) u_bank (
    .clk(clk), .rst(rst), .wr_en(byte_valid & wr_q), .wr_addr(addr_q),
    .wr_data(rx_word[BYTE_W-1:0]), .rd_addr(addr_q), .rd_data(rd_data),
    .f2_en(f2_enabled), .f2_rdy(f2_ready), .lat_bytes(lat_bytes)
  );

  assign cmd     = cmd_t'(rx_word);
  assign tx_byte = (!wr_q && dly_q == '0) ? rd_data : '0;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
      dly_q  <= '0;
    end else if (cmd_valid) begin
      wr_q   <= cmd.wr;
      addr_q <= cmd.addr;
      dly_q  <= lat_bytes[cmd.fn*BYTE_W +: BYTE_W];
    end else if (byte_valid && wr_q) begin
      addr_q <= addr_q + 1'b1;
    end else if (tx_load && !wr_q) begin
      if (dly_q != '0) dly_q  <= dly_q - 1'b1;
      else             addr_q <= addr_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
  parameter logic [7:0] F1_LAT_RST = 8'd4
) (
  input logic        clk,
  input logic        rst,
  input logic        active,
  input logic        spi_miso,
  input logic        cmd_valid,
  input logic        byte_valid,
  input logic        tx_load,
  input logic        wr_q,
  input logic [7:0]  dly_q,
  input logic [31:0] lat_bytes
);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !active |=> !spi_miso);

  a_r8_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (active && wr_q) |=> !spi_miso);

  a_r5_filler_zero: assert property (@(posedge clk) disable iff (rst)
    (tx_load && !wr_q && dly_q != 8'd0) |=> !spi_miso);

  a_r1_one_event: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_valid, byte_valid, tx_load}));

  a_r4_reset_latency: assert property (@(posedge clk)
    $past(rst) |-> (lat_bytes == {8'd0, 8'd0, F1_LAT_RST, 8'd0}));
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.F1_LAT_RST(F1_LAT_RST)) u_chk (
  .clk(clk), .rst(rst), .active(active), .spi_miso(spi_miso),
  .cmd_valid(cmd_valid), .byte_valid(byte_valid), .tx_load(tx_load),
  .wr_q(wr_q), .dly_q(dly_q), .lat_bytes(lat_bytes)
);

// File: tb/spi_reg_slave_test.sv
module spi_reg_slave_test;
  localparam int HALF = 8;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic f2_enabled = 1'b0, f2_ready = 1'b0;
  logic spi_miso;

  int total = 0, bad = 0, quiet_ones;
  exp_t exp_q[$];
  logic [7:0] got_q[$];
  logic [7:0] wbuf [8];
  event got_ev;

  always #2 clk = ~clk;

  spi_reg_slave uut (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .f2_enabled(f2_enabled), .f2_ready(f2_ready)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_t e;
    e.v = v;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(got_ev);
      while (got_q.size() != 0) begin
        logic [7:0] g;
        exp_t e;
        g = got_q.pop_front();
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected read byte", g, 0);
        end else begin
          e = exp_q.pop_front();
          check(g == e.v, e.tag, "read byte", g, e.v);
        end
      end
    end
  end

  task automatic bit_io(input logic b, output logic r);
    spi_mosi = b;
    repeat (HALF) @(negedge clk);
    r = spi_miso;
    spi_sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sclk = 1'b0;
  endtask

  task automatic xfer(input bit wr, input logic [1:0] fn, input logic [16:0] addr,
                      input int n, input logic [10:0] len);
    logic [31:0] cmd;
    logic r;
    logic [7:0] rb;
    cmd = {wr, fn, addr, 1'b0, len};
    quiet_ones = 0;
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 31; i >= 0; i--) begin
      bit_io(cmd[i], r);
      quiet_ones += int'(r);
    end
    for (int b = 0; b < n; b++) begin
      for (int k = 7; k >= 0; k--) begin
        bit_io(wr ? wbuf[b][k] : 1'b0, r);
        rb[k] = r;
      end
      if (wr) quiet_ones += $countones(rb);
      else begin
        got_q.push_back(rb);
        -> got_ev;
      end
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check(spi_miso == 1'b0, "R8", "miso after select high", spi_miso, 0);
    check(quiet_ones == 0, "R8", "miso ones in command/write", quiet_ones, 0);
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic wr_bytes(input logic [1:0] fn, input logic [16:0] addr, input int n);
    xfer(1'b1, fn, addr, n, 11'(n));
  endtask

  task automatic fillers(input int d);
    for (int i = 0; i < d; i++) expect_byte(8'h00, "R5");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(spi_miso == 1'b0, "R8", "miso at reset", spi_miso, 0);

    // R3 scratch reset value, R4 latency reset values
    for (int i = 0; i < 4; i++) expect_byte(8'h00, "R3");
    xfer(1'b0, 2'd0, 17'h18, 4, 11'd4);
    expect_byte(8'h00, "R4"); expect_byte(8'h04, "R4");
    expect_byte(8'h00, "R4"); expect_byte(8'h00, "R4");
    xfer(1'b0, 2'd0, 17'h1C, 4, 11'd4);

    // R2 signature, R1 length field does not limit the transfer
    expect_byte(8'hAD, "R2"); expect_byte(8'hBE, "R2");
    expect_byte(8'hED, "R2"); expect_byte(8'hFE, "R2");
    xfer(1'b0, 2'd0, 17'h14, 4, 11'd1);

    // R5 function 1 default latency of four fillers
    fillers(4);
    expect_byte(8'hAD, "R5"); expect_byte(8'hBE, "R5");
    xfer(1'b0, 2'd1, 17'h14, 6, 11'd2);

    // R3 scratch write and read back
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr_bytes(2'd0, 17'h18, 4);
    expect_byte(8'h11, "R3"); expect_byte(8'h22, "R3");
    expect_byte(8'h33, "R3"); expect_byte(8'h44, "R3");
    xfer(1'b0, 2'd0, 17'h18, 4, 11'd4);

    // R4 write function-2 latency, R5 write with function 1 has no fillers
    wbuf[0] = 8'h02;
    wr_bytes(2'd1, 17'h1E, 1);
    expect_byte(8'h00, "R4"); expect_byte(8'h04, "R4");
    expect_byte(8'h02, "R4"); expect_byte(8'h00, "R4");
    xfer(1'b0, 2'd0, 17'h1C, 4, 11'd4);
    fillers(2);
    expect_byte(8'h11, "R5"); expect_byte(8'h22, "R5");
    xfer(1'b0, 2'd2, 17'h18, 4, 11'd2);

    // R4/R5 clear function-1 latency, read without fillers
    wbuf[0] = 8'h00;
    wr_bytes(2'd0, 17'h1D, 1);
    expect_byte(8'hAD, "R5");
    xfer(1'b0, 2'd1, 17'h14, 1, 11'd1);

    // R6 status word with both flag patterns
    f2_enabled = 1'b1; f2_ready = 1'b0;
    expect_byte(8'h01, "R6"); expect_byte(8'h20, "R6");
    xfer(1'b0, 2'd0, 17'h0E, 2, 11'd2);
    f2_enabled = 1'b0; f2_ready = 1'b1;
    expect_byte(8'h02, "R6"); expect_byte(8'h20, "R6");
    xfer(1'b0, 2'd3, 17'h0E, 2, 11'd2);

    // R7 writes to read-only and unmapped addresses are ignored
    wbuf[0] = 8'h55; wbuf[1] = 8'h66;
    wr_bytes(2'd0, 17'h14, 2);
    wr_bytes(2'd0, 17'h0E, 2);
    wr_bytes(2'd0, 17'h40, 2);
    wr_bytes(2'd0, 17'h10018, 1);
    expect_byte(8'hAD, "R7"); expect_byte(8'hBE, "R7");
    xfer(1'b0, 2'd0, 17'h14, 2, 11'd2);
    expect_byte(8'h02, "R7"); expect_byte(8'h20, "R7");
    xfer(1'b0, 2'd0, 17'h0E, 2, 11'd2);
    expect_byte(8'h00, "R7"); expect_byte(8'h00, "R7");
    xfer(1'b0, 2'd0, 17'h40, 2, 11'd2);
    expect_byte(8'h00, "R7"); expect_byte(8'h11, "R7");
    xfer(1'b0, 2'd0, 17'h10017, 1, 11'd1);
    xfer(1'b0, 2'd0, 17'h18, 1, 11'd1);

    // R1 address increments across unmapped bytes into the signature
    expect_byte(8'h00, "R1"); expect_byte(8'h00, "R1");
    expect_byte(8'hAD, "R1"); expect_byte(8'hBE, "R1");
    xfer(1'b0, 2'd0, 17'h12, 4, 11'd0);

    // R9 partial command discarded when select rises
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 12; i++) bit_io(1'b1, r);
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (3 * HALF) @(negedge clk);
    check(spi_miso == 1'b0, "R8", "miso idle after abort", spi_miso, 0);
    expect_byte(8'hAD, "R9"); expect_byte(8'hBE, "R9");
    expect_byte(8'hED, "R9"); expect_byte(8'hFE, "R9");
    xfer(1'b0, 2'd0, 17'h14, 4, 11'd4);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R1", "expected bytes left over", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule